// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two 4-byte entries from memory. A root register gives the base of the page directory. The top ten bits of the linear address select an entry in that directory, and the entry points to a page table. The next ten bits select an entry in that page table, and that entry gives the 4096-byte page frame. The low twelve bits pass through unchanged and become the byte offset inside the frame. Bit 0 of each entry is a present flag. If the flag is clear at either level, the walk stops and the block returns a fault.

A request is taken with a valid/ready handshake. Each memory read is a one-cycle request pulse on a read port. The walker then waits, for as long as it takes, for a one-cycle read-valid that carries the data. The result stays on a valid/ready response port until it is taken. Only one walk is in progress at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: `req_ready` is 1 only while the walker is idle. It stays 0 from the cycle after a request is accepted until the response has been taken.
- R3: In the cycle after a request is accepted, `mem_rd_req` pulses for one cycle. The address is `{root[31:12], va[31:22], 2'b00}`. Bits 11:0 of the root register are ignored.
- R4: When the directory entry returns with bit 0 set, `mem_rd_req` pulses in the next cycle. The address is `{dir_entry[31:12], va[21:12], 2'b00}`.
- R5: When the table entry returns with bit 0 set, the response gives `rsp_fault` = 0 and `rsp_paddr` = `{tbl_entry[31:12], va[11:0]}`.
- R6: When the directory entry has bit 0 clear, the response gives `rsp_fault` = 1 and `rsp_paddr` = 0. No table read is issued.
- R7: When the table entry has bit 0 clear, the response gives `rsp_fault` = 1 and `rsp_paddr` = 0.
- R8: The walker waits any number of cycles for `mem_rd_valid` at each level, and the result does not depend on that latency.
- R9: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until `rsp_ready` is seen. In the cycle after the handshake, `rsp_valid` is 0 and `req_ready` is 1.
- R10: `root_we` loads `root_wdata` into the root register. A write made during an active walk changes only the reads of later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Root register write strobe |
| root_wdata | input | 32 | New page directory base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Linear address to translate |
| mem_rd_req | output | 1 | One-cycle read request pulse |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid, one cycle |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | A non-present entry was met |

## Verification
The hardest case to reach is a root register write that lands in the middle of a walk. The new base must not affect the walk already in progress, and it must apply to the very next request. The bench writes the root while the directory read is still outstanding. It then runs a second walk and compares both read addresses with values computed from the old root and the new root.

Faults at each level are forced by stimulus that clears the present bit of the chosen entry in the bench memory. A hash fills the rest of that memory, so random walks also meet natural faults.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            root_we,
  input  logic [VA_W-1:0] root_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            mem_rd_req,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [VA_W-1:0] mem_rd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault
);
  localparam int MID_LO = OFS_W;
  localparam int TOP_LO = OFS_W + IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_RSP} st_t;

  st_t             st;
  logic [VA_W-1:0] root_q;
  logic [VA_W-1:0] va_q;

  function automatic logic [VA_W-1:0] ent_addr(input logic [VA_W-1:0] base,
                                               input logic [VA_W-1:0] idx);
    return ((base >> OFS_W) << OFS_W) | (idx << 2);
  endfunction

  assign req_ready = (st == S_IDLE);

  wire accept  = req_valid && req_ready;
  wire present = mem_rd_data[0];
  wire unused_bits = ^{mem_rd_data[OFS_W-1:1], root_q[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      root_q      <= '0;
      va_q        <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
    end else begin
      mem_rd_req <= 1'b0;
      if (root_we) root_q <= root_wdata;
      case (st)
        S_IDLE: if (accept) begin
          va_q        <= req_vaddr;
          mem_rd_addr <= ent_addr(root_q, VA_W'(req_vaddr[VA_W-1:TOP_LO]));
          mem_rd_req  <= 1'b1;
          st          <= S_DIR;
        end
        S_DIR: if (mem_rd_valid) begin
          if (present) begin
            mem_rd_addr <= ent_addr(mem_rd_data, VA_W'(va_q[TOP_LO-1:MID_LO]));
            mem_rd_req  <= 1'b1;
            st          <= S_TBL;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            st        <= S_RSP;
          end
        end
        S_TBL: if (mem_rd_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= !present;
          rsp_paddr <= present ? {mem_rd_data[VA_W-1:OFS_W], va_q[OFS_W-1:0]} : '0;
          st        <= S_RSP;
        end
        S_RSP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: the directory read follows acceptance by exactly one cycle
  p_dir_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_req);

  // R3: a read request is a single-cycle pulse
  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  // R2: no new request is taken while a result is pending
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: the response holds until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R6: a fault carries no physical address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R5: the byte offset passes through untouched
  p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, root_we, req_valid, req_ready, mem_rd_req, mem_rd_valid;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [31:0] root_wdata, req_vaddr, mem_rd_addr, mem_rd_data, rsp_paddr;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  int nvec = 0;
  int nbad = 0;
  logic [31:0] root_model = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // clr: 0 natural, 1 clear directory present, 2 clear table present, 3 force present
  function automatic logic [31:0] memfn(input logic [31:0] a, input int lvl, input int clr);
    logic [31:0] h;
    logic p;
    h = (a * 32'h9E3779B1) ^ (a >> 7) ^ 32'h5A5A1234;
    p = (h[5:2] != 4'd0);
    if (clr == lvl + 1) p = 1'b0;
    if (clr == 3) p = 1'b1;
    return {h[31:1], p};
  endfunction

  task automatic write_root(input logic [31:0] v);
    @(negedge clk); root_we = 1'b1; root_wdata = v;
    @(negedge clk); root_we = 1'b0;
    root_model = v;
  endtask

  task automatic walk(input logic [31:0] va, input int clr, input int lat_max,
                      input int rdly, input bit do_root, input logic [31:0] newroot,
                      input string tag);
    logic [31:0] da, dw, ta, tw, epa, pw, hp;
    logic ef, hf;
    int eread, nr, cnt, it;
    bit pend, got, busy_bad;
    string rt;
    da = {root_model[31:12], 12'h0} | {20'h0, va[31:22], 2'b00};
    dw = memfn(da, 0, clr);
    ta = {dw[31:12], 12'h0} | {20'h0, va[21:12], 2'b00};
    tw = memfn(ta, 1, clr);
    if (!dw[0]) begin ef = 1'b1; epa = '0; eread = 1; rt = "R6"; end
    else if (!tw[0]) begin ef = 1'b1; epa = '0; eread = 2; rt = "R7"; end
    else begin ef = 1'b0; epa = {tw[31:12], va[11:0]}; eread = 2; rt = "R5"; end
    @(negedge clk); req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    nr = 0; pend = 0; cnt = 0; it = 0; got = 0; busy_bad = 0; pw = '0;
    while (!got) begin
      mem_rd_valid = 1'b0; root_we = 1'b0;
      if (do_root && it == 1) begin root_we = 1'b1; root_wdata = newroot; end
      if (pend) begin
        if (cnt == 0) begin mem_rd_valid = 1'b1; mem_rd_data = pw; pend = 0; end
        else cnt--;
      end
      if (mem_rd_req) begin
        if (nr == 0) chk(mem_rd_addr == da, {"R3 dir addr ", tag}, mem_rd_addr, da);
        else chk(mem_rd_addr == ta, {"R4 tbl addr ", tag}, mem_rd_addr, ta);
        pw = memfn(mem_rd_addr, nr, clr);
        nr++; pend = 1; cnt = $urandom_range(lat_max, 0);
      end
      if (rsp_valid) got = 1;
      else begin
        if (req_ready) busy_bad = 1;
        @(negedge clk); it++;
      end
    end
    root_we = 1'b0; mem_rd_valid = 1'b0;
    if (do_root) root_model = newroot;
    chk(!busy_bad, {"R2 ready low while busy ", tag}, 32'(busy_bad), 0);
    chk(nr == eread, {rt, " read count ", tag}, nr, eread);
    chk(rsp_fault == ef, {rt, " fault ", tag}, 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr == epa, {rt, " paddr ", tag}, rsp_paddr, epa);
    hp = rsp_paddr; hf = rsp_fault;
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == hp && rsp_fault == hf && !req_ready,
          {"R9 hold ", tag}, rsp_paddr, hp);
    end
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {"R9 release ", tag}, {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    #800000;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; root_we = 1'b0; root_wdata = '0; req_valid = 1'b0; req_vaddr = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_req, "R1 reset state",
        {29'h0, req_ready, rsp_valid, mem_rd_req}, 32'h4);

    write_root(32'h1234_5ABC);  // low bits must be ignored (R10, R3)
    walk(32'h0040_3123, 3, 2, 0, 0, '0, "directed present");
    walk(32'hFFFF_FFFF, 3, 1, 1, 0, '0, "all ones");
    walk(32'h0000_0000, 3, 0, 0, 0, '0, "all zeros");
    walk(32'h8765_4321, 1, 2, 2, 0, '0, "dir fault");
    walk(32'h1357_9BDF, 2, 2, 0, 0, '0, "tbl fault");
    walk(32'h2468_ACE0, 3, 25, 0, 0, '0, "R8 long latency");
    walk(32'h2468_ACE0, 3, 0, 0, 0, '0, "R8 zero latency");
    walk(32'h0BAD_F00D, 3, 3, 6, 0, '0, "R9 slow consumer");
    walk(32'hCAFE_0123, 3, 4, 0, 1, 32'h7700_0FFF, "R10 root write mid walk");
    walk(32'hCAFE_0123, 3, 1, 0, 0, '0, "R10 next walk uses new root");

    for (int n = 0; n < 80; n++) begin
      walk($urandom, (n % 7 == 0) ? 3 : 0, $urandom_range(6, 0), $urandom_range(3, 0),
           (n % 11 == 5), $urandom, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule